// File: doc/BRIEF.md
# Sigma-delta ADC serial register interface

This block is the serial register front end of a sigma-delta converter. It acts as an SPI slave in mode 3: the clock idles high, input is taken on the rising SCLK edge and output changes on the falling edge. Every transfer starts with an 8-bit command byte. That byte picks one of eight register addresses and a direction. A data phase of the register's own width follows, MSB first. SCLK, chip select and MOSI are oversampled by the system clock, so SCLK must be several system clocks slow.

Conversion results come in on a parallel port that has a one-cycle valid strobe. Each result is latched together with its error flag and its channel number, and it raises a ready flag. The MISO pin carries that flag inverted whenever no read data is being shifted out: a low level means a fresh result is waiting. In continuous mode, results are fetched by plain clocking with no command in front.

An unbroken run of ones on MOSI resets the serial state machine. The mode and configuration words drive the converter core through two output ports.

Top module: `sdadc_serial_regs`

## Requirements
- R1: Command byte: bit 7 must be 0, bit 6 = 1 for read and 0 for write, bits 5:3 = address, bit 2 = continuous-read request. A byte with bit 7 set is dropped with no data phase, and the next 8 bits are taken as a new command.
- R2: Register address map and data-phase widths:
  - 0: status, 8 bits, read-only. A write to address 0 has no data phase.
  - 1: mode, 16 bits.
  - 2: configuration, 16 bits.
  - 3: result, DW bits, read-only.
  - 4: identity, 8 bits, read-only.
  - 5: IO, 8 bits.
  - 6: offset, DW bits.
  - 7: full-scale, DW bits.
  - All data phases shift MSB first.
- R3: Status reads as {ready, error, 3'b000, channel[2:0]}. Identity reads as {4'h0, DEV_ID}.
- R4: Writes to addresses 1, 2, 5, 6 and 7 take effect after the last data bit. mode_word and cfg_word show addresses 1 and 2, and reset to MODE_INIT and CONF_INIT. Write data phases to addresses 3 and 4 are consumed and discarded.
- R5: A conv_valid pulse latches conv_data, conv_err and conv_chan and sets ready. While no read data is being shifted out, miso_rdy equals the inverse of ready.
- R6: Decoding a read command for address 3 clears ready. If conv_valid arrives in that same cycle, ready stays set, and the read returns the result held before the strobe.
- R7: A read command for address 3 with bit 2 set turns on continuous mode. In that mode, when ready is set and no transfer is under way, the next falling SCLK edge starts a DW-bit result transfer with no command, and that transfer clears ready.
- R8: Continuous mode ends in either of two ways:
  - the last 8 MOSI bits of a result transfer match a read of address 3 without bit 2 (byte 0x58);
  - a read command for address 3 without bit 2 is decoded.
- R9: RESET_ONES consecutive ones sampled on MOSI return the serial logic to wait for a command and end continuous mode. Registers keep their values.
- R10: Raising cs_n abandons any partial command or data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data in |
| miso_rdy | output | 1 | Serial data out, or the inverted ready flag when idle |
| conv_valid | input | 1 | One-cycle strobe for a new conversion result |
| conv_data | input | DW | Conversion result |
| conv_err | input | 1 | Over- or underrange flag for the result |
| conv_chan | input | 3 | Channel that produced the result |
| mode_word | output | 16 | Current mode register |
| cfg_word | output | 16 | Current configuration register |

## Verification
Two events can fall in the same system-clock cycle: a result strobe, and the decode of a read command for the result register. One clears ready and the other sets it. The bench pins the strobe to the exact cycle in which the eighth rising SCLK edge is seen, then judges the outcome from three observations:
- the bits shifted out must be the older result;
- the idle MISO level afterwards must be low, meaning ready is still set;
- a second read must return the new result.

// File: rtl/sdadc_serial_regs.sv
module sdadc_serial_regs #(
  parameter int          DW         = 24,
  parameter logic [3:0]  DEV_ID     = 4'hB,
  parameter int          RESET_ONES = 32,
  parameter logic [15:0] MODE_INIT  = 16'h000A,
  parameter logic [15:0] CONF_INIT  = 16'h0710
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso_rdy,
  input  logic          conv_valid,
  input  logic [DW-1:0] conv_data,
  input  logic          conv_err,
  input  logic [2:0]    conv_chan,
  output logic [15:0]   mode_word,
  output logic [15:0]   cfg_word
);
  localparam int CW = $clog2(DW + 1);
  localparam int OW = $clog2(RESET_ONES + 1);

  typedef enum logic [1:0] {S_CMD, S_WR, S_RD} st_t;

  logic sclk_r, sclk_p, cs_r, mosi_r;
  st_t st;
  logic [CW-1:0] cnt;
  logic [OW-1:0] ones;
  logic [7:0] cmd_sr;
  logic [2:0] addr;
  logic [DW-1:0] sr_out, rd_word, data_q, offs_q, fs_q;
  logic [DW-2:0] sr_in;
  logic [7:0] io_q;
  logic [2:0] chan_q;
  logic fresh, cont, rdy, err_q;

  wire rise      = sclk_r & ~sclk_p;
  wire fall      = ~sclk_r & sclk_p;
  wire [7:0] cmd_next = {cmd_sr[6:0], mosi_r};
  wire [DW-1:0] wv    = {sr_in, mosi_r};
  wire ones_hit  = !cs_r && rise && mosi_r && ones == OW'(RESET_ONES - 1);
  wire cmd_done  = st == S_CMD && rise && cnt == CW'(7);

  function automatic logic [CW-1:0] xfer_len(input logic [2:0] a, input logic rd);
    case (a)
      3'd0:       return rd ? CW'(8) : CW'(0);
      3'd1, 3'd2: return CW'(16);
      3'd4, 3'd5: return CW'(8);
      default:    return CW'(DW);
    endcase
  endfunction

  always_comb begin
    case (cmd_next[5:3])
      3'd0:    rd_word = {rdy, err_q, 3'b000, chan_q, {(DW-8){1'b0}}};
      3'd1:    rd_word = {mode_word, {(DW-16){1'b0}}};
      3'd2:    rd_word = {cfg_word, {(DW-16){1'b0}}};
      3'd3:    rd_word = data_q;
      3'd4:    rd_word = {4'h0, DEV_ID, {(DW-8){1'b0}}};
      3'd5:    rd_word = {io_q, {(DW-8){1'b0}}};
      3'd6:    rd_word = offs_q;
      default: rd_word = fs_q;
    endcase
  end

  assign miso_rdy = (st == S_RD) ? sr_out[DW-1] : ~rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sclk_r, sclk_p, cs_r, mosi_r} <= 4'b1110;
      st <= S_CMD; cnt <= '0; ones <= '0; cmd_sr <= '0; addr <= '0;
      sr_out <= '0; sr_in <= '0; fresh <= 1'b0; cont <= 1'b0;
      rdy <= 1'b0; err_q <= 1'b0; chan_q <= '0; data_q <= '0;
      mode_word <= MODE_INIT; cfg_word <= CONF_INIT; io_q <= '0;
      offs_q <= {1'b1, {(DW-1){1'b0}}}; fs_q <= {3'b010, {(DW-3){1'b0}}};
    end else begin
      sclk_r <= sclk; sclk_p <= sclk_r; cs_r <= cs_n; mosi_r <= mosi;
      if (cs_r) begin
        st <= S_CMD; cnt <= '0; ones <= '0; fresh <= 1'b0;
      end else if (ones_hit) begin
        st <= S_CMD; cnt <= '0; ones <= '0; fresh <= 1'b0; cont <= 1'b0;
      end else begin
        if (rise) ones <= mosi_r ? ones + 1'b1 : '0;
        case (st)
          S_CMD:
            if (rise) begin
              cmd_sr <= cmd_next;
              cnt <= cnt + 1'b1;
              if (cnt == CW'(7)) begin
                cnt <= '0;
                if (!cmd_next[7]) begin
                  addr <= cmd_next[5:3];
                  if (cmd_next[6]) begin
                    st <= S_RD; sr_out <= rd_word; fresh <= 1'b1;
                    cnt <= xfer_len(cmd_next[5:3], 1'b1);
                    if (cmd_next[5:3] == 3'd3) begin
                      rdy <= 1'b0; cont <= cmd_next[2];
                    end
                  end else if (xfer_len(cmd_next[5:3], 1'b0) != '0) begin
                    st <= S_WR; cnt <= xfer_len(cmd_next[5:3], 1'b0);
                  end
                end
              end
            end else if (fall && cont && rdy && cnt == '0) begin
              st <= S_RD; sr_out <= data_q; fresh <= 1'b0;
              cnt <= CW'(DW); addr <= 3'd3; rdy <= 1'b0;
            end
          S_WR:
            if (rise) begin
              sr_in <= wv[DW-2:0];
              cnt <= cnt - 1'b1;
              if (cnt == CW'(1)) begin
                st <= S_CMD; cnt <= '0;
                case (addr)
                  3'd1: mode_word <= wv[15:0];
                  3'd2: cfg_word  <= wv[15:0];
                  3'd5: io_q      <= wv[7:0];
                  3'd6: offs_q    <= wv;
                  3'd7: fs_q      <= wv;
                  default: ;
                endcase
              end
            end
          default:
            if (rise) begin
              cmd_sr <= cmd_next;
              cnt <= cnt - 1'b1;
              if (cnt == CW'(1)) begin
                st <= S_CMD; cnt <= '0;
                if (cont && addr == 3'd3 && cmd_next[7:2] == 6'b010110) cont <= 1'b0;
              end
            end else if (fall) begin
              if (fresh) fresh <= 1'b0;
              else sr_out <= {sr_out[DW-2:0], 1'b0};
            end
        endcase
      end
      if (conv_valid) begin
        data_q <= conv_data; err_q <= conv_err; chan_q <= conv_chan; rdy <= 1'b1;
      end
    end
  end

  assert_ready_on_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |=> rdy);
  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_valid |=> $stable(data_q));
  assert_read_clears_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !cs_r && !ones_hit && cmd_next[7:3] == 5'b01011 && !conv_valid) |=> !rdy);
  assert_mode_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_word) |-> $past(st == S_WR && addr == 3'd1));
  assert_ones_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ones_hit |=> (st == S_CMD && !cont && cnt == '0));
  assert_cs_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_r |=> (st == S_CMD && cnt == '0));
endmodule

// File: tb/tb_sdadc_serial_regs.sv
module tb_sdadc_serial_regs;
  localparam int DW = 24;
  logic clk = 0, rst_n = 0, sclk = 1, cs_n = 1, mosi = 0;
  logic conv_valid = 0, conv_err = 0;
  logic [DW-1:0] conv_data = '0, coll_data = '0;
  logic [2:0] conv_chan = '0;
  logic miso_rdy;
  logic [15:0] mode_word, cfg_word;
  int total = 0, bad = 0;
  bit done = 0;

  sdadc_serial_regs dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso_rdy(miso_rdy), .conv_valid(conv_valid), .conv_data(conv_data), .conv_err(conv_err),
    .conv_chan(conv_chan), .mode_word(mode_word), .cfg_word(cfg_word));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic sbit(input logic b, input logic coll, output logic o);
    @(negedge clk); sclk = 0; mosi = b;
    repeat (4) @(negedge clk);
    o = miso_rdy; sclk = 1;
    if (coll) begin
      @(negedge clk); conv_valid = 1; conv_data = coll_data;
      @(negedge clk); conv_valid = 0;
      repeat (2) @(negedge clk);
    end else repeat (4) @(negedge clk);
  endtask

  task automatic xfer(input int n, input logic [31:0] tx, output logic [31:0] rx);
    logic o;
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sbit(tx[i], 1'b0, o);
      rx = {rx[30:0], o};
    end
  endtask

  task automatic rd(input logic [7:0] cmd, input int n, output logic [31:0] rx);
    logic [31:0] d;
    xfer(8, {24'h0, cmd}, d);
    xfer(n, 32'h0, rx);
  endtask

  task automatic wr(input logic [7:0] cmd, input int n, input logic [31:0] v);
    logic [31:0] d;
    xfer(8, {24'h0, cmd}, d);
    xfer(n, v, d);
  endtask

  task automatic strobe(input logic [DW-1:0] d, input logic e, input logic [2:0] c);
    @(negedge clk); conv_valid = 1; conv_data = d; conv_err = e; conv_chan = c;
    @(negedge clk); conv_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R5 idle miso after reset", {31'h0, miso_rdy}, 32'h1);
    check("R4 mode reset", {16'h0, mode_word}, 32'h000A);
    check("R4 config reset", {16'h0, cfg_word}, 32'h0710);
  endtask

  task automatic t_id;
    logic [31:0] r;
    rd(8'h60, 8, r); check("R3 identity read", r, 32'h0B);
    rd(8'h48, 16, r); check("R2 mode read width", r, 32'h000A);
  endtask

  task automatic t_writes;
    logic [31:0] r;
    wr(8'h08, 16, 32'h2345); repeat (4) @(negedge clk);
    check("R4 mode_word", {16'h0, mode_word}, 32'h2345);
    rd(8'h48, 16, r); check("R2 mode readback", r, 32'h2345);
    wr(8'h10, 16, 32'h1234); repeat (4) @(negedge clk);
    check("R4 cfg_word", {16'h0, cfg_word}, 32'h1234);
    wr(8'h28, 8, 32'hA5); rd(8'h68, 8, r); check("R4 io readback", r, 32'hA5);
    wr(8'h30, 24, 32'h123456); rd(8'h70, 24, r); check("R4 offset readback", r, 32'h123456);
    wr(8'h38, 24, 32'h654321); rd(8'h78, 24, r); check("R4 fullscale readback", r, 32'h654321);
    check("R4 mode untouched by others", {16'h0, mode_word}, 32'h2345);
  endtask

  task automatic t_readonly;
    logic [31:0] r;
    strobe(24'h00C3C3, 1'b0, 3'd0);
    wr(8'h20, 8, 32'hF0); rd(8'h60, 8, r); check("R4 identity write discarded", r, 32'h0B);
    wr(8'h18, 24, 32'h5A5A00); rd(8'h58, 24, r); check("R4 result write discarded", r, 32'h00C3C3);
    wr(8'h00, 0, 32'h0); rd(8'h60, 8, r); check("R2 write to address 0 has no data phase", r, 32'h0B);
  endtask

  task automatic t_invalid;
    logic [31:0] r;
    xfer(8, 32'hC8, r);
    rd(8'h60, 8, r); check("R1 bit7 set ignored", r, 32'h0B);
  endtask

  task automatic t_result;
    logic [31:0] r;
    strobe(24'hABCDEF, 1'b1, 3'd2);
    check("R5 miso low when ready", {31'h0, miso_rdy}, 32'h0);
    rd(8'h40, 8, r); check("R3 status ready/err/chan", r, 32'hC2);
    rd(8'h58, 24, r); check("R6 result read", r, 32'hABCDEF);
    rd(8'h40, 8, r); check("R6 ready cleared by result read", r, 32'h42);
    check("R5 miso high when not ready", {31'h0, miso_rdy}, 32'h1);
  endtask

  task automatic t_collision;
    logic [31:0] r, d;
    logic o;
    strobe(24'h0A0B0C, 1'b0, 3'd1);
    xfer(7, 32'h2C, d);
    coll_data = 24'h0D0E0F;
    sbit(1'b0, 1'b1, o);
    xfer(24, 32'h0, r); check("R6 same-cycle read returns old", r, 32'h0A0B0C);
    repeat (4) @(negedge clk);
    check("R6 ready kept after collision", {31'h0, miso_rdy}, 32'h0);
    rd(8'h58, 24, r); check("R6 second read returns new", r, 32'h0D0E0F);
  endtask

  task automatic t_cont;
    logic [31:0] r;
    rd(8'h5C, 24, r); check("R7 entry read", r, 32'h0D0E0F);
    strobe(24'h111111, 1'b0, 3'd0);
    check("R7 ready shown in continuous mode", {31'h0, miso_rdy}, 32'h0);
    xfer(24, 32'h0, r); check("R7 commandless read 1", r, 32'h111111);
    repeat (4) @(negedge clk);
    check("R7 ready cleared by continuous read", {31'h0, miso_rdy}, 32'h1);
    strobe(24'h222222, 1'b0, 3'd0);
    xfer(24, 32'h58, r); check("R8 commandless read with exit byte", r, 32'h222222);
    strobe(24'h333333, 1'b0, 3'd0);
    rd(8'h40, 8, r); check("R8 continuous mode left", r, 32'h80);
  endtask

  task automatic t_ones;
    logic [31:0] r;
    xfer(3, 32'h0, r);
    xfer(32, 32'hFFFFFFFF, r);
    rd(8'h60, 8, r); check("R9 ones run resyncs", r, 32'h0B);
  endtask

  task automatic t_cs;
    logic [31:0] r;
    cs_n = 0;
    xfer(3, 32'h2, r);
    @(negedge clk); cs_n = 1; repeat (6) @(negedge clk); cs_n = 0; repeat (2) @(negedge clk);
    rd(8'h60, 8, r); check("R10 chip select abort", r, 32'h0B);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset;
    cs_n = 0; repeat (2) @(negedge clk);
    t_id; t_writes; t_readonly; t_invalid; t_result; t_collision; t_cont; t_ones; t_cs;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule